// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block sits between a port's pin inputs and its register bank. Each cycle it samples the pins of every bit configured as an input. It folds those levels into the port data value and hands the result back to the bank as the next data value. For each pin it decides whether the latest sample counts as an interrupt event. That decision uses per-bit trigger settings: level or edge, any-edge or single-edge, and a polarity bit. Each event is then steered through two independent mask words onto two interrupt lines, A and B.

The bank supplies the current data word and all the configuration words. It writes the returned data word back every clock, so the previous level of every pin is the matching data bit. Synchronizers and the bus interface are outside this block.

Top module: `gpio_pin_irq_detect`

## Requirements
- R1: For a pin bit i (i < NPINS) with both `cfg_dir[i]` and `cfg_inen[i]` equal to 1, `data_o[i]` equals `pin_i[i]` in the same cycle.
- R2: For a pin bit whose `cfg_dir` or `cfg_inen` bit is 0, `data_o[i]` equals `data_i[i]` and that pin produces no event, whatever its level or trigger settings.
- R3: With `cfg_edge[i]`=1 and `cfg_single[i]`=0, an enabled pin produces an event exactly when `pin_i[i]` differs from `data_i[i]`.
- R4: With `cfg_edge[i]`=1 and `cfg_single[i]`=1, `cfg_polar[i]`=0 selects a rising edge only (`data_i[i]`=0, `pin_i[i]`=1) and `cfg_polar[i]`=1 selects a falling edge only.
- R5: With `cfg_edge[i]`=0, an enabled pin produces an event on every sample whose level differs from `cfg_polar[i]`: high when polar is 0, low when polar is 1.
- R6: An event on pin i reaches interrupt A only if `cfg_mask_a[i]`=1 and interrupt B only if `cfg_mask_b[i]`=1; the two masks act independently.
- R7: `irq_a_o` and `irq_b_o` are registered. Each is high in the cycle after a cycle in which any pin had an event passing its mask, and low after a cycle with none.
- R8: Data bits at and above NPINS have no pin; `data_o` passes them from `data_i` unchanged.
- R9: While `rst_n` is low both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Pin levels, already synchronized |
| data_i | input | WIDTH | Current port data word from the bank |
| cfg_dir | input | WIDTH | Direction bits, 1 = input |
| cfg_inen | input | WIDTH | Input-buffer enable bits |
| cfg_edge | input | WIDTH | 1 = edge trigger, 0 = level trigger |
| cfg_single | input | WIDTH | In edge mode, 1 = single edge chosen by polarity, 0 = any edge |
| cfg_polar | input | WIDTH | Polarity bits |
| cfg_mask_a | input | WIDTH | Enables for interrupt A |
| cfg_mask_b | input | WIDTH | Enables for interrupt B |
| data_o | output | WIDTH | Next port data word for the bank |
| irq_a_o | output | 1 | Interrupt A, one clock per event cycle |
| irq_b_o | output | 1 | Interrupt B, one clock per event cycle |

## Verification
The bench builds the block at its defaults: fifteen pins in a sixteen-bit word. This leaves bit 15 as a pinless bit whose passthrough can be observed. Random configuration words at full width make every mix of enable, trigger mode and polarity appear on different pins in one cycle. The OR across pins and the independence of the two masks are therefore exercised together. A bank model in the bench feeds the expected data word back each clock, so edge decisions see a realistic history of levels.

// File: rtl/gpio_pin_irq_detect.sv
module gpio_pin_irq_detect #(
  parameter int NPINS = 15,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] cfg_dir,
  input  logic [WIDTH-1:0] cfg_inen,
  input  logic [WIDTH-1:0] cfg_edge,
  input  logic [WIDTH-1:0] cfg_single,
  input  logic [WIDTH-1:0] cfg_polar,
  input  logic [WIDTH-1:0] cfg_mask_a,
  input  logic [WIDTH-1:0] cfg_mask_b,
  output logic [WIDTH-1:0] data_o,
  output logic             irq_a_o,
  output logic             irq_b_o
);

  logic [NPINS-1:0] live;
  logic [NPINS-1:0] evt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic old_lvl, new_lvl, hit;
    assign live[i]    = cfg_dir[i] & cfg_inen[i];
    assign old_lvl    = data_i[i];
    assign new_lvl    = live[i] ? pin_i[i] : old_lvl;
    assign data_o[i]  = new_lvl;
    always_comb begin
      if (!cfg_edge[i])
        hit = new_lvl ^ cfg_polar[i];
      else if (!cfg_single[i])
        hit = new_lvl ^ old_lvl;
      else if (cfg_polar[i])
        hit = old_lvl & ~new_lvl;
      else
        hit = ~old_lvl & new_lvl;
    end
    assign evt[i] = live[i] & hit;
  end

  if (WIDTH > NPINS) begin : g_spare
    assign data_o[WIDTH-1:NPINS] = data_i[WIDTH-1:NPINS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a_o <= 1'b0;
      irq_b_o <= 1'b0;
    end else begin
      irq_a_o <= |(evt & cfg_mask_a[NPINS-1:0]);
      irq_b_o <= |(evt & cfg_mask_b[NPINS-1:0]);
    end
  end

  assert_irq_a_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_o |-> $past(|(cfg_mask_a[NPINS-1:0] & cfg_dir[NPINS-1:0] & cfg_inen[NPINS-1:0])));

  assert_irq_b_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b_o |-> $past(|(cfg_mask_b[NPINS-1:0] & cfg_dir[NPINS-1:0] & cfg_inen[NPINS-1:0])));

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_dir[NPINS-1:0] & cfg_inen[NPINS-1:0]) == '0) |=> (!irq_a_o && !irq_b_o));

  assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pin_i ^ data_i[NPINS-1:0]) & cfg_dir[NPINS-1:0] & cfg_inen[NPINS-1:0]) == '0) &&
     ((cfg_dir[NPINS-1:0] & cfg_inen[NPINS-1:0] & ~cfg_edge[NPINS-1:0]) == '0))
    |=> (!irq_a_o && !irq_b_o));

endmodule

// File: tb/gpio_pin_irq_detect_tb.sv
module gpio_pin_irq_detect_tb;
  localparam int NP = 15;
  localparam int W  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [W-1:0] data_i = '0, cfg_dir = '0, cfg_inen = '0, cfg_edge = '0;
  logic [W-1:0] cfg_single = '0, cfg_polar = '0, cfg_mask_a = '0, cfg_mask_b = '0;
  logic [W-1:0] data_o;
  logic irq_a_o, irq_b_o;
  int vectors = 0, errors = 0;
  logic [W-1:0] bank = '0;

  always #4 clk = ~clk;

  gpio_pin_irq_detect #(.NPINS(NP), .WIDTH(W)) u_dut (.*);

  function automatic logic [W-1:0] ref_data();
    logic [W-1:0] d = bank;
    for (int i = 0; i < NP; i++) if (cfg_dir[i] && cfg_inen[i]) d[i] = pin_i[i];
    return d;
  endfunction

  function automatic logic [NP-1:0] ref_evt();
    logic [NP-1:0] e = '0;
    for (int i = 0; i < NP; i++) begin
      logic o, n;
      o = bank[i]; n = pin_i[i];
      if (cfg_dir[i] && cfg_inen[i]) begin
        if (!cfg_edge[i]) e[i] = (n != cfg_polar[i]);
        else if (!cfg_single[i]) e[i] = (n != o);
        else if (cfg_polar[i]) e[i] = o && !n;
        else e[i] = !o && n;
      end
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [W-1:0] ed;
    logic [NP-1:0] ev;
    logic ea, eb;
    data_i = bank;
    #1;
    ed = ref_data();
    ev = ref_evt();
    ea = |(ev & cfg_mask_a[NP-1:0]);
    eb = |(ev & cfg_mask_b[NP-1:0]);
    chk({tag, " data"}, data_o, ed);
    @(posedge clk);
    bank = ed;
    #1;
    chk({tag, " irqA"}, {15'd0, irq_a_o}, {15'd0, ea});
    chk({tag, " irqB"}, {15'd0, irq_b_o}, {15'd0, eb});
    @(negedge clk);
  endtask

  task automatic cfg1(input logic e, input logic s, input logic p);
    cfg_dir = 16'h0001; cfg_inen = 16'h0001; cfg_edge = {15'd0, e};
    cfg_single = {15'd0, s}; cfg_polar = {15'd0, p};
    cfg_mask_a = 16'h0001; cfg_mask_b = 16'h0001;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    chk("R9 reset irqA", {15'd0, irq_a_o}, 16'd0);
    chk("R9 reset irqB", {15'd0, irq_b_o}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg1(1'b0, 1'b0, 1'b0); pin_i = '0; step("R5 level low idle");
    pin_i = 15'h1; step("R5 level high");
    step("R5 level repeats");
    cfg_polar = 16'h1; pin_i = '0; step("R5 level low active");

    cfg1(1'b1, 1'b0, 1'b0); pin_i = '0; step("R3 anyedge settle");
    pin_i = 15'h1; step("R3 anyedge rise");
    step("R3 anyedge steady");
    pin_i = '0; step("R3 anyedge fall");

    cfg1(1'b1, 1'b1, 1'b0); pin_i = 15'h1; step("R4 rise on rising");
    pin_i = '0; step("R4 fall ignored on rising");
    cfg_polar = 16'h1; pin_i = 15'h1; step("R4 rise ignored on falling");
    pin_i = '0; step("R4 fall on falling");

    cfg1(1'b0, 1'b0, 1'b0); cfg_inen = '0; bank = 16'h0000; pin_i = 15'h7FFF;
    step("R2 inen off");
    cfg_inen = 16'hFFFF; cfg_dir = '0; step("R2 dir off");

    cfg1(1'b0, 1'b0, 1'b0); cfg_dir = 16'hFFFF; cfg_inen = 16'hFFFF;
    cfg_edge = '0; cfg_polar = '0; pin_i = 15'h0010;
    cfg_mask_a = 16'h0010; cfg_mask_b = 16'h0000; step("R6 only A");
    cfg_mask_a = 16'h0000; cfg_mask_b = 16'h0010; step("R6 only B");
    cfg_mask_a = 16'h4000; cfg_mask_b = 16'h4000; step("R6 unmasked pin");

    bank = 16'h8000; pin_i = '0; step("R8 spare bit kept");
    bank = 16'h0000; pin_i = 15'h5A5A; cfg_polar = 16'hFFFF; step("R1 all inputs");

    for (int k = 0; k < 400; k++) begin
      pin_i = NP'($urandom); cfg_dir = W'($urandom | $urandom);
      cfg_inen = W'($urandom | $urandom); cfg_edge = W'($urandom);
      cfg_single = W'($urandom); cfg_polar = W'($urandom);
      cfg_mask_a = W'($urandom & $urandom); cfg_mask_b = W'($urandom & $urandom);
      if (k % 50 == 0) bank = W'($urandom);
      step("R7 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule